// File: doc/BRIEF.md
# Memory Command Frame Parser

This block sits behind a UART receiver and turns a stream of received bytes into memory accesses. A frame opens with a start byte. An optional device-select byte follows, and then a control byte and a four-byte memory address. Write frames carry 1 to 32 payload bytes. A CRC-16 may follow, and a closing byte ends the frame. The parser checks the framing, the optional CRC and the allowed address window. A valid write is replayed as consecutive single-byte writes on a simple memory port. A valid read becomes a one-cycle request to the response path.

Every frame that is addressed to this device ends in exactly one status result: success (code 0x00) or one error code. Write payload is held in an internal buffer. The buffer is released to memory only after the closing byte, the CRC and the address window have all been accepted. A rejected frame therefore never changes memory.

Top module: `cmdframe_parser`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid`, `mem_we` and `rd_req` are low.
- R2: A byte received while idle that is not the start byte (default 0x68) gives, in the following cycle, a `res_valid` pulse with `res_error`=1 and code 0xE1. The parser stays idle, so a correct frame that follows is processed normally.
- R3: The frame order is: start, device-select byte (present when enabled, default 0xAD), control, address, payload (writes only), CRC (only when enabled in the frame), closing byte. The address arrives least significant byte first. In the control byte, bit 7 is the command (1 write, 0 read), bit 6 enables the CRC, bits 4:0 hold the length minus one, and bit 5 is ignored.
- R4: An accepted write of N bytes drives `mem_we` for N consecutive cycles. The addresses run from base to base+N-1, and the payload bytes are written in the order they were received.
- R5: An accepted read produces, one cycle after the closing byte, a single cycle in which `rd_req` and `res_valid` are both high. In that cycle `rd_addr` equals the base address, `rd_len` equals N, `res_error` is 0 and the code is 0x00.
- R6: A closing byte other than the configured one (default 0x16) gives code 0xE2, with no memory write and no read request.
- R7: With CRC enabled, a CRC-16 is computed over start, device-select, control, address and payload. It uses polynomial 0x1021, seed 0xFFFF, MSB first, no reflection and no final XOR. The received value arrives low byte first. A mismatch gives code 0xE4 and no access.
- R8: If any byte from base to base+N-1 lies outside the window set by ADDR_LO and ADDR_HI (inclusive), the result is code 0xE3 and no access is made.
- R9: When a frame has more than one fault, the reported code is chosen in this order of priority: 0xE2 first, then 0xE4, then 0xE3.
- R10: The success result of a write arrives in the cycle after its last memory write. No result is ever reported in the same cycle as a memory write.
- R11: A frame whose device-select byte differs from the configured value is consumed up to its closing byte. It produces no result, no write and no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| rd_req | output | 1 | Read request pulse to response path |
| rd_addr | output | 32 | Read base address |
| rd_len | output | 6 | Read length in bytes (1..32) |
| res_valid | output | 1 | Status result pulse |
| res_error | output | 1 | Status is an error |
| res_code | output | 8 | 0x00 success, else 0xE1..0xE4 |

## Verification
The hardest cases to reach from the ports are frames with several faults at once, and accesses that end exactly on, or one byte past, the top of the window. Only these cases expose the priority of the error codes and the off-by-one edge of the span check. Directed frames therefore combine a wrong closing byte, a corrupted CRC and an out-of-window address in each pairing, and place 32-byte accesses at both window edges. A seeded random loop then mixes commands, lengths, CRC use and addresses drawn near the edges, with occasional injected faults.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_CTRL, ST_ADDR, ST_DATA, ST_CRC, ST_CLOSE, ST_WRITE
  } cfp_state_e;

  localparam logic [7:0] CODE_OK    = 8'h00;
  localparam logic [7:0] CODE_START = 8'hE1;
  localparam logic [7:0] CODE_CLOSE = 8'hE2;
  localparam logic [7:0] CODE_RANGE = 8'hE3;
  localparam logic [7:0] CODE_CRC   = 8'hE4;

  localparam int CTL_CMD_BIT = 7;
  localparam int CTL_CRC_BIT = 6;
endpackage

// File: rtl/cfp_crc16.sv
module cfp_crc16 #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] SEED = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  logic [15:0] crc_q, crc_d;

  function automatic logic [15:0] step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  always_comb begin
    crc_d = crc_q;
    if (init)     crc_d = step(SEED, din);
    else if (upd) crc_d = step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= SEED;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/cfp_byte_buf.sv
module cfp_byte_buf #(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/cfp_range_chk.sv
module cfp_range_chk #(
  parameter int          AW    = 32,
  parameter int          LEN_W = 5,
  parameter logic [AW-1:0] LO  = '0,
  parameter logic [AW-1:0] HI  = '1
) (
  input  logic [AW-1:0]    base,
  input  logic [LEN_W-1:0] len_m1,
  output logic             in_window
);
  logic [AW:0] last;

  always_comb begin
    last      = {1'b0, base} + {{(AW+1-LEN_W){1'b0}}, len_m1};
    in_window = (base >= LO) && (last <= {1'b0, HI});
  end
endmodule

// File: rtl/cmdframe_parser.sv
module cmdframe_parser #(
  parameter logic [7:0]  START_BYTE = 8'h68,
  parameter logic [7:0]  CLOSE_BYTE = 8'h16,
  parameter bit          SEL_EN     = 1'b1,
  parameter logic [7:0]  SEL_BYTE   = 8'hAD,
  parameter logic [31:0] ADDR_LO    = 32'h2020_0000,
  parameter logic [31:0] ADDR_HI    = 32'h2020_7FFF,
  parameter int          MAX_LEN    = 32,
  localparam int         LEN_W      = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             rd_req,
  output logic [31:0]      rd_addr,
  output logic [LEN_W:0]   rd_len,
  output logic             res_valid,
  output logic             res_error,
  output logic [7:0]       res_code
);
  import cfp_pkg::*;

  cfp_state_e       state_q, state_d;
  logic             cmd_wr_q, cmd_wr_d;
  logic             crc_on_q, crc_on_d;
  logic             foreign_q, foreign_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic [31:0]      addr_q, addr_d;
  logic [15:0]      rxcrc_q, rxcrc_d;
  logic             res_valid_q, res_valid_d;
  logic             res_error_q, res_error_d;
  logic [7:0]       res_code_q, res_code_d;
  logic             rd_req_q, rd_req_d;

  logic             crc_init, crc_upd;
  logic [15:0]      crc_calc;
  logic             buf_we;
  logic [7:0]       buf_rd;
  logic             in_window;
  logic             crc_bad;

  cfp_crc16 #(.POLY(16'h1021), .SEED(16'hFFFF)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd),
    .din(rx_byte), .crc(crc_calc)
  );

  cfp_byte_buf #(.DEPTH(MAX_LEN), .IDX_W(LEN_W)) u_buf (
    .clk(clk), .wr_en(buf_we), .wr_idx(idx_q), .wr_data(rx_byte),
    .rd_idx(idx_q), .rd_data(buf_rd)
  );

  cfp_range_chk #(.AW(32), .LEN_W(LEN_W), .LO(ADDR_LO), .HI(ADDR_HI)) u_range (
    .base(addr_q), .len_m1(len_q), .in_window(in_window)
  );

  assign crc_bad = crc_on_q && (rxcrc_q != crc_calc);
  assign buf_we  = rx_valid && (state_q == ST_DATA);

  // The CRC covers everything from the start byte through the payload.
  always_comb begin
    crc_init = rx_valid && (state_q == ST_IDLE) && (rx_byte == START_BYTE);
    crc_upd  = rx_valid && ((state_q == ST_SEL) || (state_q == ST_CTRL) ||
                            (state_q == ST_ADDR) || (state_q == ST_DATA));
  end

  always_comb begin
    state_d     = state_q;
    cmd_wr_d    = cmd_wr_q;
    crc_on_d    = crc_on_q;
    foreign_d   = foreign_q;
    len_d       = len_q;
    idx_d       = idx_q;
    addr_d      = addr_q;
    rxcrc_d     = rxcrc_q;
    res_valid_d = 1'b0;
    res_error_d = res_error_q;
    res_code_d  = res_code_q;
    rd_req_d    = 1'b0;

    case (state_q)
      ST_IDLE: if (rx_valid) begin
        if (rx_byte == START_BYTE) begin
          foreign_d = 1'b0;
          state_d   = SEL_EN ? ST_SEL : ST_CTRL;
        end else begin
          res_valid_d = 1'b1;
          res_error_d = 1'b1;
          res_code_d  = CODE_START;
        end
      end
      ST_SEL: if (rx_valid) begin
        foreign_d = (rx_byte != SEL_BYTE);
        state_d   = ST_CTRL;
      end
      ST_CTRL: if (rx_valid) begin
        cmd_wr_d = rx_byte[CTL_CMD_BIT];
        crc_on_d = rx_byte[CTL_CRC_BIT];
        len_d    = rx_byte[LEN_W-1:0];
        idx_d    = '0;
        state_d  = ST_ADDR;
      end
      ST_ADDR: if (rx_valid) begin
        addr_d[{idx_q[1:0], 3'b000} +: 8] = rx_byte;
        idx_d = idx_q + 1'b1;
        if (idx_q[1:0] == 2'd3) begin
          idx_d = '0;
          if (cmd_wr_q)      state_d = ST_DATA;
          else if (crc_on_q) state_d = ST_CRC;
          else               state_d = ST_CLOSE;
        end
      end
      ST_DATA: if (rx_valid) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == len_q) begin
          idx_d   = '0;
          state_d = crc_on_q ? ST_CRC : ST_CLOSE;
        end
      end
      ST_CRC: if (rx_valid) begin
        rxcrc_d[{idx_q[0], 3'b000} +: 8] = rx_byte;
        idx_d = idx_q + 1'b1;
        if (idx_q[0]) begin
          idx_d   = '0;
          state_d = ST_CLOSE;
        end
      end
      ST_CLOSE: if (rx_valid) begin
        state_d = ST_IDLE;
        idx_d   = '0;
        if (!foreign_q) begin
          if (rx_byte != CLOSE_BYTE) begin
            res_valid_d = 1'b1; res_error_d = 1'b1; res_code_d = CODE_CLOSE;
          end else if (crc_bad) begin
            res_valid_d = 1'b1; res_error_d = 1'b1; res_code_d = CODE_CRC;
          end else if (!in_window) begin
            res_valid_d = 1'b1; res_error_d = 1'b1; res_code_d = CODE_RANGE;
          end else if (cmd_wr_q) begin
            state_d = ST_WRITE;
          end else begin
            res_valid_d = 1'b1; res_error_d = 1'b0; res_code_d = CODE_OK;
            rd_req_d    = 1'b1;
          end
        end
      end
      ST_WRITE: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == len_q) begin
          idx_d       = '0;
          state_d     = ST_IDLE;
          res_valid_d = 1'b1;
          res_error_d = 1'b0;
          res_code_d  = CODE_OK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cmd_wr_q    <= 1'b0;
      crc_on_q    <= 1'b0;
      foreign_q   <= 1'b0;
      len_q       <= '0;
      idx_q       <= '0;
      addr_q      <= '0;
      rxcrc_q     <= '0;
      res_valid_q <= 1'b0;
      res_error_q <= 1'b0;
      res_code_q  <= CODE_OK;
      rd_req_q    <= 1'b0;
    end else begin
      state_q     <= state_d;
      cmd_wr_q    <= cmd_wr_d;
      crc_on_q    <= crc_on_d;
      foreign_q   <= foreign_d;
      len_q       <= len_d;
      idx_q       <= idx_d;
      addr_q      <= addr_d;
      rxcrc_q     <= rxcrc_d;
      res_valid_q <= res_valid_d;
      res_error_q <= res_error_d;
      res_code_q  <= res_code_d;
      rd_req_q    <= rd_req_d;
    end
  end

  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = addr_q + {{(32-LEN_W){1'b0}}, idx_q};
  assign mem_wdata = buf_rd;
  assign rd_req    = rd_req_q;
  assign rd_addr   = addr_q;
  assign rd_len    = {1'b0, len_q} + 1'b1;
  assign res_valid = res_valid_q;
  assign res_error = res_error_q;
  assign res_code  = res_code_q;
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker #(
  parameter logic [7:0] START_BYTE = 8'h68
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic [7:0]  rx_byte,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        rd_req,
  input logic        res_valid,
  input logic        res_error,
  input logic [7:0]  res_code
);
  // R2: an 0xE1 result always follows a received byte that was not the start byte
  p_start_err_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 8'hE1) |-> ($past(rx_valid) && $past(rx_byte) != START_BYTE));

  // R4: consecutive writes step through consecutive addresses
  p_wr_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 32'd1));

  // R5: a read request travels with a success result
  p_rd_with_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (res_valid && !res_error && res_code == 8'h00));

  // R9: error results carry one of the four defined codes
  p_err_code_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_error) |-> (res_code >= 8'hE1 && res_code <= 8'hE4));

  // R10: the write burst ends with a success result in the next cycle
  p_wr_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we) |-> (res_valid && !res_error));

  // R10: result and memory write never share a cycle
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && res_valid));
endmodule

bind cmdframe_parser cfp_checker #(.START_BYTE(START_BYTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .mem_we(mem_we), .mem_addr(mem_addr), .rd_req(rd_req),
  .res_valid(res_valid), .res_error(res_error), .res_code(res_code)
);

// File: tb/cmdframe_parser_tb.sv
module cmdframe_parser_tb;
  localparam logic [31:0] LO = 32'h2020_0000;
  localparam logic [31:0] HI = 32'h2020_7FFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic [5:0]  rd_len;
  logic        res_valid;
  logic        res_error;
  logic [7:0]  res_code;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cmdframe_parser u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
    .res_valid(res_valid), .res_error(res_error), .res_code(res_code)
  );

  // Expected-write bookkeeping and monitor state
  logic [7:0]  td [32];
  logic [31:0] exp_base;
  int          wr_seen, res_seen, rd_seen;
  logic [7:0]  got_code;
  logic        got_err;
  logic [31:0] got_rd_addr;
  logic [5:0]  got_rd_len;
  logic [7:0]  fr [48];
  int          flen;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (wr_seen < 32) begin
          check(mem_addr == exp_base + wr_seen, "R4 write address", mem_addr, exp_base + wr_seen);
          check(mem_wdata == td[wr_seen], "R4 write data", mem_wdata, td[wr_seen]);
        end
        wr_seen++;
      end
      if (res_valid) begin
        res_seen++;
        got_code = res_code;
        got_err  = res_error;
      end
      if (rd_req) begin
        rd_seen++;
        got_rd_addr = rd_addr;
        got_rd_len  = rd_len;
      end
    end
  end

  function automatic logic [15:0] crc_ref(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--)
        c = ((c[15] ^ fr[k][b]) != 1'b0) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
    return c;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    if (($urandom % 4) == 0) @(negedge clk);
  endtask

  task automatic clear_mon();
    wr_seen = 0; res_seen = 0; rd_seen = 0;
  endtask

  // Build one frame, send it, and check the outcome against a computed model.
  task automatic run_frame(input bit wr, input bit crcen, input int len, input logic [31:0] addr,
                           input bit bad_close, input bit bad_crc, input bit bad_sel, input string tag);
    logic [15:0] c;
    logic [7:0]  exp_code;
    bit          in_win;
    longint      last;
    flen = 0;
    fr[flen++] = 8'h68;
    fr[flen++] = bad_sel ? 8'hAC : 8'hAD;
    fr[flen++] = {wr, crcen, 1'($urandom % 2), 5'(len - 1)};
    for (int k = 0; k < 4; k++) fr[flen++] = addr[8*k +: 8];
    if (wr) for (int k = 0; k < len; k++) begin
      td[k] = 8'($urandom);
      fr[flen++] = td[k];
    end
    if (crcen) begin
      c = crc_ref(flen);
      if (bad_crc) c = c ^ 16'h0100;
      fr[flen++] = c[7:0];
      fr[flen++] = c[15:8];
    end
    fr[flen++] = bad_close ? 8'h17 : 8'h16;

    last     = longint'(addr) + len - 1;
    in_win   = (addr >= LO) && (last <= longint'(HI));
    exp_code = bad_close ? 8'hE2 : (crcen && bad_crc) ? 8'hE4 : !in_win ? 8'hE3 : 8'h00;
    exp_base = addr;

    clear_mon();
    for (int k = 0; k < flen; k++) send_byte(fr[k]);
    for (int t = 0; t < 80 && res_seen == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);

    if (bad_sel) begin
      check(res_seen == 0, {tag, " R11 foreign frame result"}, res_seen, 0);
      check(wr_seen == 0 && rd_seen == 0, {tag, " R11 foreign frame access"}, wr_seen + rd_seen, 0);
    end else begin
      check(res_seen == 1, {tag, " R3 one result"}, res_seen, 1);
      check(got_code == exp_code && got_err == (exp_code != 8'h00),
            {tag, " R9 result code"}, got_code, exp_code);
      check(wr_seen == ((wr && exp_code == 8'h00) ? len : 0), {tag, " R4 write count"},
            wr_seen, (wr && exp_code == 8'h00) ? len : 0);
      if (!wr && exp_code == 8'h00) begin
        check(rd_seen == 1 && got_rd_addr == addr, {tag, " R5 read address"}, got_rd_addr, addr);
        check(got_rd_len == 6'(len), {tag, " R5 read length"}, got_rd_len, len);
      end else begin
        check(rd_seen == 0, {tag, " R6 no read request"}, rd_seen, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
    clear_mon();
    repeat (3) @(negedge clk);
    check(!res_valid && !mem_we && !rd_req, "R1 outputs in reset", {res_valid, mem_we, rd_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!res_valid && !mem_we && !rd_req, "R1 outputs after reset", {res_valid, mem_we, rd_req}, 0);

    // R2: stray byte gives 0xE1, then resynchronise
    clear_mon();
    send_byte(8'h55);
    repeat (2) @(negedge clk);
    check(res_seen == 1 && got_code == 8'hE1 && got_err, "R2 stray byte code", got_code, 8'hE1);
    run_frame(1, 1, 4, 32'h2020_7C00, 0, 0, 0, "R2 resync write");

    // R3/R7: CRC on and off, read and write
    run_frame(0, 1, 4, 32'h2020_7C00, 0, 0, 0, "R7 read crc");
    run_frame(1, 0, 1, LO, 0, 0, 0, "R3 write nocrc low edge");
    run_frame(0, 0, 32, 32'h2020_1000, 0, 0, 0, "R3 read nocrc max");
    // R8: window edges
    run_frame(1, 1, 32, HI - 31, 0, 0, 0, "R8 top edge fits");
    run_frame(1, 1, 32, HI - 30, 0, 0, 0, "R8 top edge over");
    run_frame(0, 0, 1, LO - 1, 0, 0, 0, "R8 below window");
    run_frame(0, 0, 2, 32'hFFFF_FFFF, 0, 0, 0, "R8 wrap");
    // R6/R7/R9: faults and priority
    run_frame(1, 1, 8, 32'h2020_0100, 1, 0, 0, "R6 bad close");
    run_frame(1, 1, 8, 32'h2020_0100, 0, 1, 0, "R7 bad crc");
    run_frame(1, 1, 8, HI, 1, 1, 0, "R9 close over crc and range");
    run_frame(0, 1, 8, HI, 0, 1, 0, "R9 crc over range");
    run_frame(1, 0, 8, 32'h2020_0100, 0, 1, 0, "R7 crc off ignores");
    // R11: foreign device
    run_frame(1, 1, 4, 32'h2020_0200, 0, 0, 1, "R11 foreign write");
    run_frame(1, 1, 3, 32'h2020_0300, 0, 0, 0, "R11 after foreign");

    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      int          l;
      l = 1 + ($urandom % 32);
      case ($urandom % 3)
        0:       a = LO + ($urandom % 32'h7000);
        1:       a = HI - ($urandom % 40);
        default: a = LO - 4 + ($urandom % 8);
      endcase
      run_frame(1'($urandom % 2), 1'($urandom % 2), l, a,
                ($urandom % 10) == 0, ($urandom % 7) == 0, ($urandom % 15) == 0, "R4 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule